// File: doc/BRIEF.md
# Serial Port with Fractional Baud Generator

This block is a byte-oriented asynchronous serial port that sits behind a small register bus. Software pushes bytes into a 32-entry transmit queue and pops bytes from a 32-entry receive queue. Both queues are reached through one data register. A status register reports whether receive data is waiting and whether the transmit queue has room. Frames are 8N1: one low start bit, eight data bits with the least significant first, one high stop bit. The line idles high.

Bit timing comes from a divisor word W, the number of block clock cycles in one bit time. W is written as two fields: a high part holding W >> 6 and a low part holding W & 63. A modulo accumulator turns W into sixteen oversampling ticks per bit. When W is not a multiple of 16, the tick spacing alternates so that the average bit time is exactly W cycles.

Each register access completes in the cycle it is presented, so the bus has no back-pressure. A write to a full transmit queue is discarded. A read of an empty receive queue returns zero. Serial input and output are plain level pins.

Top module: `uartf_top`

## Requirements
- R1: Word address 0 is the data register, with the byte in bits 7:0. Address 1 is status. Address 2 holds the divisor high part (W >> 6). Address 3 holds the divisor low part (W & 63) in bits 5:0. A read of address 0 returns the oldest received byte in bits 7:0 and removes it from the queue.
- R2: The transmitter sends 8N1 frames: start bit 0, then data bits LSB first, then stop bit 1. Each bit lasts W cycles. `txd` is 1 while idle and out of reset.
- R3: Status bit 4 is 1 when the receive queue is empty. Status bit 5 is 1 when the transmit queue is full. All other status bits read 0. After reset, status reads 0x0010.
- R4: W = high*64 + low. A value of W below 16 behaves as 16. After reset, high = 1 and low = 0, so W = 64. A write to either divisor register restarts the tick phase. While frames are sent back to back, consecutive start edges are exactly 10*W cycles apart, including when W is not a multiple of 16.
- R5: The transmit queue holds 32 bytes. A data write while the queue is full is discarded and never sent.
- R6: A data read while the receive queue is empty returns 0 and leaves the queue empty.
- R7: The receiver detects a low line on an oversampling tick and re-checks it about half a bit later. If the line is high at that point, the start is discarded and nothing is queued. Otherwise each data bit is sampled near its middle.
- R8: A received frame whose stop bit samples low is discarded. A frame whose stop bit samples high is queued in the receive queue, which holds 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bit timing is counted in these cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data, valid in the same cycle as the read strobe |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions check four properties on every cycle. Loading a frame drives the line low on the next cycle. A full transmit queue stays full until the transmitter takes a byte. An empty receive queue stays empty until the receiver queues a byte. With divisors of 32 or more, oversampling ticks never occur on adjacent cycles.

Other behaviour needs the bench's scenarios. These include the exact 10*W frame spacing with a fractional divisor, the bit order on the line, and the rejection of a short start pulse or a low stop bit. The bench also checks that a 33rd queued byte never appears at the far end of a loopback.

// File: rtl/uartf_pkg.sv
package uartf_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_DIVH = 2'd2,
    REG_DIVL = 2'd3
  } reg_sel_e;

  localparam int FRAC_W   = 6;
  localparam int OVS      = 16;
  localparam int ST_RXE   = 4;
  localparam int ST_TXF   = 5;
  localparam int FRAME_BITS = 10;
endpackage

// File: rtl/uartf_fifo.sv
module uartf_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uartf_baud.sv
module uartf_baud #(
  parameter int DIV_W = 22,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int AW = DIV_W + 1;

  logic [AW-1:0] acc, eff, sum;

  assign eff = (div < DIV_W'(OVS)) ? AW'(OVS) : {1'b0, div};
  assign sum = acc + AW'(OVS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (restart) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (sum >= eff) begin
      acc  <= sum - eff;
      tick <= 1'b1;
    end else begin
      acc  <= sum;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uartf_tx.sv
module uartf_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       txd
);
  localparam int CW = $clog2(OVS);

  logic [9:0]    sh;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic          busy, bit_end, last, load;

  assign bit_end  = busy && tick && (cnt == CW'(OVS-1));
  assign last     = bit_end && (bitn == 4'd9);
  assign load     = tick && (!busy || last) && !fifo_empty;
  assign fifo_pop = load;
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      bitn <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= {1'b1, fifo_data, 1'b0};
      bitn <= '0;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (bit_end) begin
        cnt <= '0;
        sh  <= {1'b1, sh[9:1]};
        if (last) busy <= 1'b0;
        else      bitn <= bitn + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uartf_rx.sv
module uartf_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] data
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS/2 - 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e        st;
  logic [1:0]    sync;
  logic          rs;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic          full_bit;

  assign rs       = sync[1];
  assign full_bit = tick && (cnt == CW'(OVS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      data <= '0;
      push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            cnt <= '0;
            if (!rs) st <= RX_START;
          end
          RX_START: begin
            if (cnt == CW'(HALF)) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rs ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (full_bit) begin
              data <= {rs, data[7:1]};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) st <= RX_STOP;
            end
          end
          default: begin
            cnt <= cnt + 1'b1;
            if (full_bit) begin
              push <= rs;
              st   <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uartf_top.sv
module uartf_top
  import uartf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd
);
  localparam int DIV_W = DW + FRAC_W;

  logic [DW-1:0]     div_hi;
  logic [FRAC_W-1:0] div_lo;
  logic [DIV_W-1:0]  div;
  logic              wr, rd, div_wr, tick;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0]        tx_data;
  logic              rx_push, rx_pop, rx_empty, rx_full_unused;
  logic [7:0]        rx_data, rx_head;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign div_wr  = wr && (sel == REG_DIVH || sel == REG_DIVL);
  assign tx_push = wr && (sel == REG_DATA);
  assign rx_pop  = rd && (sel == REG_DATA);
  assign div     = {div_hi, div_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_hi <= DW'(1);
      div_lo <= '0;
    end else if (wr) begin
      if (sel == REG_DIVH) div_hi <= bus_wdata;
      if (sel == REG_DIVL) div_lo <= bus_wdata[FRAC_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_DATA: if (!rx_empty) bus_rdata[7:0] = rx_head;
      REG_STAT: begin
        bus_rdata[ST_RXE] = rx_empty;
        bus_rdata[ST_TXF] = tx_full;
      end
      REG_DIVH: bus_rdata = div_hi;
      default:  bus_rdata[FRAC_W-1:0] = div_lo;
    endcase
  end

  uartf_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .restart(div_wr), .tick(tick)
  );

  uartf_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full)
  );

  uartf_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(tx_empty),
    .fifo_data(tx_data), .fifo_pop(tx_pop), .txd(txd)
  );

  uartf_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .push(rx_push), .data(rx_data)
  );

  uartf_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full_unused)
  );
endmodule

// File: rtl/uartf_chk.sv
module uartf_chk #(
  parameter int DIV_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_pop,
  input logic             tx_full,
  input logic             rx_push,
  input logic             rx_empty,
  input logic             txd,
  input logic             tick,
  input logic             div_wr,
  input logic [DIV_W-1:0] div
);
  // R2: a loaded frame begins with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !txd);

  // R5: a full transmit queue is not changed by writes
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_pop |=> tx_full);

  // R6: reading an empty receive queue leaves it empty
  a_r6_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && !rx_push |=> rx_empty);

  // R4: with W of 32 or more, ticks are never adjacent
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div >= DIV_W'(32)) && tick && !div_wr |=> !tick);
endmodule

bind uartf_top uartf_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pop(tx_pop), .tx_full(tx_full),
  .rx_push(rx_push), .rx_empty(rx_empty), .txd(txd), .tick(tick),
  .div_wr(div_wr), .div(div)
);

// File: tb/tb_uartf_top.sv
module tb_uartf_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          txd, rxd, loop = 1'b1, rx_drv = 1'b1;
  int            total = 0, bad = 0;
  int            cyc = 0;
  int            nfall = 0, fall_last = 0, fall_prev = 0;
  logic          done = 1'b0;

  assign rxd = loop ? txd : rx_drv;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge txd) begin
    fall_prev = fall_last;
    fall_last = cyc;
    nfall++;
  end

  uartf_top #(.DW(DW), .DEPTH(32)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd)
  );

  localparam logic [7:0] VEC [6] = '{8'h00, 8'h55, 8'hA5, 8'hFF, 8'h81, 8'h3C};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_rx(input int limit, output bit got);
    logic [DW-1:0] s;
    got = 1'b0;
    for (int i = 0; i < limit && !got; i++) begin
      rd(2'd1, s);
      if (!s[4]) got = 1'b1;
      else repeat (8) @(posedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic send_line(input logic [7:0] b, input logic stop, input int bt);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); rx_drv = fr[k];
      repeat (bt - 1) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    bit got;
    int n0;

    do_reset();
    // reset state
    rd(2'd1, d); check(d == 16'h0010, "R3 reset status", d, 16'h0010);
    check(txd == 1'b1, "R2 idle txd", txd, 1);
    rd(2'd2, d); check(d == 16'd1, "R4 reset div high", d, 1);
    rd(2'd3, d); check(d == 16'd0, "R4 reset div low", d, 0);
    // R6: empty read
    rd(2'd0, d); check(d == 16'd0, "R6 empty read value", d, 0);
    rd(2'd1, d); check(d == 16'h0010, "R6 status after empty read", d, 16'h0010);

    // vector loop: loopback at W=64 (R1, R2, R8)
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {8'h00, VEC[i]});
      wait_rx(400, got);
      rd(2'd0, d);
      check(got && d == {8'h00, VEC[i]}, "R1 loopback byte", d, VEC[i]);
    end

    // R2: bit order of 0xA5 on the line, sampled mid-bit at W=64
    begin
      logic [9:0] fr, seen;
      fr = {1'b1, 8'hA5, 1'b0};
      wr(2'd0, 16'h00A5);
      @(negedge txd);
      for (int k = 0; k < 10; k++) begin
        repeat ((k == 0) ? 32 : 64) @(posedge clk);
        #1 seen[k] = txd;
      end
      check(seen == fr, "R2 frame bits LSB first", seen, fr);
      wait_rx(400, got); rd(2'd0, d);
    end

    // R4: back-to-back spacing, integer divisor W=64
    repeat (200) @(posedge clk);
    n0 = nfall;
    wr(2'd0, 16'h00FF); wr(2'd0, 16'h00FF);
    for (int i = 0; i < 4000 && nfall < n0 + 2; i++) @(posedge clk);
    check(fall_last - fall_prev == 640, "R4 spacing W=64", fall_last - fall_prev, 640);
    wait_rx(400, got); rd(2'd0, d); wait_rx(400, got); rd(2'd0, d);

    // R4: fractional divisor W=100 (high=1, low=36)
    repeat (800) @(posedge clk);
    wr(2'd3, 16'd36);
    n0 = nfall;
    wr(2'd0, 16'h00FF); wr(2'd0, 16'h00FF);
    for (int i = 0; i < 6000 && nfall < n0 + 2; i++) @(posedge clk);
    check(fall_last - fall_prev == 1000, "R4 spacing W=100", fall_last - fall_prev, 1000);
    wait_rx(600, got); rd(2'd0, d);
    check(got && d == 16'h00FF, "R4 fractional loopback", d, 16'h00FF);
    wait_rx(600, got); rd(2'd0, d);
    repeat (1200) @(posedge clk);
    wr(2'd3, 16'd0);

    // R7: short low pulse is a false start
    loop = 1'b0; rx_drv = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk); rx_drv = 1'b0;
    repeat (12) @(negedge clk);
    rx_drv = 1'b1;
    repeat (2000) @(posedge clk);
    rd(2'd1, d); check(d == 16'h0010, "R7 false start dropped", d, 16'h0010);

    // R8: low stop bit drops the frame
    send_line(8'h3C, 1'b0, 64);
    repeat (1500) @(posedge clk);
    rd(2'd1, d); check(d == 16'h0010, "R8 framing error dropped", d, 16'h0010);
    // R7: externally timed frame accepted
    send_line(8'h3C, 1'b1, 64);
    wait_rx(400, got); rd(2'd0, d);
    check(got && d == 16'h003C, "R7 mid-bit sampled byte", d, 16'h003C);

    // R5: 33rd write to a full queue is dropped
    loop = 1'b1;
    do_reset();
    wr(2'd2, 16'd1023); wr(2'd3, 16'd63);
    for (int i = 0; i < 32; i++) wr(2'd0, 16'(i));
    wr(2'd0, 16'h00EE);
    rd(2'd1, d); check(d == 16'h0030, "R5 status full", d, 16'h0030);
    wr(2'd2, 16'd0); wr(2'd3, 16'd16);
    repeat (6000) @(posedge clk);
    for (int i = 0; i < 32; i++) begin
      rd(2'd0, d); check(d == 16'(i), "R5 queued byte order", d, i);
    end
    rd(2'd1, d); check(d == 16'h0010, "R5 dropped byte never sent", d, 16'h0010);

    finish_run();
  end
endmodule